// File: doc/BRIEF.md
# Bit-Addressed Interrupt Status Register

This block is the eight-bit status and control byte of a peripheral card's local controller. The byte lives in a window of eight consecutive I/O offsets, with one offset for each bit. Bits 0 to 6 are sticky event flags. Hardware events set them, and any local-processor access to a flag's own offset clears it. Reads return the whole byte on the low data lane, so firmware sees every flag at once.

The flags record the following events:
- a vector-register access that is not an interrupt acknowledge;
- a host attention access;
- the serial controller's interrupt;
- a DMA or debugger fault;
- a bus abort, together with whether that abort hit a DMA transfer or programmed I/O;
- a delayed main-memory access that locks the bus.

Bit 7 is the active-low interrupt request toward the host. Firmware raises it by writing 0 through offset 7. A host acknowledge, or a negating access to offset 7, drops the request.

Bit 7 is held by a two-state machine. State `HREQ_IDLE` drives the bit high and state `HREQ_PEND` drives it low. The machine has two transitions:
- `REQUEST` goes from idle to pending on a write of 0 to offset 7.
- `RELEASE` goes from pending to idle on a host acknowledge, a read of offset 7, or a write of 1 to offset 7.

Top module: `attn_status_reg`

## Requirements
- R1: After reset, `rd_data` is 8'h80, `host_irq_n` is 1 and `local_irq` is 0.
- R2: A local access (`acc_valid`=1, read or write) to offset n, for n from 0 to 5, clears bit n at the next clock edge and leaves the other bits unchanged, unless a set event for bit n arrives in the same cycle.
- R3: Set events map to bits as follows. Serial interrupt sets bit 2. Host attention sets bit 1. A DMA fault or a debugger fault sets bit 3. A delayed memory access sets bit 6. A bus abort sets bit 4. Each bit is visible one edge after its event.
- R4: When a set event and a clearing access hit the same bit in the same cycle, the bit is 1 afterwards.
- R5: A vector-register access sets bit 0 only when the interrupt-acknowledge qualifier is 0.
- R6: A bus abort loads bit 5 with the DMA qualifier: 1 means the abort occurred during DMA, 0 means it occurred during programmed I/O.
- R7: An access to offset 6 clears bit 6 only while no dummy read is pending. While a dummy read is pending, bit 6 holds.
- R8: In state HREQ_IDLE, a write to offset 7 with `acc_wbit`=0 moves to HREQ_PEND, which drives bit 7 and `host_irq_n` to 0. Writes with `acc_wbit`=1 and reads leave the idle state unchanged.
- R9: In state HREQ_PEND, any of the following returns to HREQ_IDLE, with bit 7 at 1: `host_ack`, a read of offset 7, or a write to offset 7 with `acc_wbit`=1. `host_ack` wins over a simultaneous request write.
- R10: `rd_data` always shows the full register. `local_irq[3:0]` equals bits 3 to 0, and `host_irq_n` equals bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| acc_valid | input | 1 | Local access to the register window this cycle |
| acc_wr | input | 1 | Access is a write (0 = read) |
| acc_offset | input | 3 | Offset within the window, which is also the bit index |
| acc_wbit | input | 1 | Write data bit 0 (used only at offset 7) |
| ev_vector_acc | input | 1 | Access to the ID/vector register |
| ev_vector_iack | input | 1 | That vector access is an interrupt acknowledge |
| ev_host_attn | input | 1 | Host attention access |
| ev_serial_irq | input | 1 | Serial controller interrupt |
| ev_dma_fault | input | 1 | Peripheral fault during DMA |
| ev_dbg_fault | input | 1 | Debugger fault |
| ev_abort | input | 1 | Bus abort occurred; DMA is blocked |
| ev_abort_dma | input | 1 | The abort occurred during DMA (1) or PIO (0) |
| ev_mem_delay | input | 1 | Local main-memory access delayed (bus locked) |
| dummy_pend | input | 1 | Dummy read pending; blocks clearing of bit 6 |
| host_ack | input | 1 | Host acknowledge of the interrupt request |
| rd_data | output | 8 | Full register contents |
| host_irq_n | output | 1 | Active-low interrupt request to the host |
| local_irq | output | 4 | Local interrupt lines, one for each of bits 0 to 3 |

## Verification
Every register bit changes on the first rising edge after the cycle in which its event, access or acknowledge is presented. The outputs are read straight from those registers, so each result is due exactly one edge after its stimulus. The bench drives a stimulus on a falling edge and lets one rising edge pass. It compares all outputs on the next falling edge against a bench model advanced by one step, so no comparison is made early or late.

// File: rtl/asr_pkg.sv
package asr_pkg;
    localparam int REG_W   = 8;
    localparam int OFS_W   = $clog2(REG_W);
    localparam int FLAG_N  = REG_W - 1;
    localparam int IRQ_N   = 4;
    localparam int LOCK_BIT  = 6;
    localparam int KIND_BIT  = 5;
    localparam int ABORT_BIT = 4;
    localparam int FAULT_BIT = 3;
    localparam int SER_BIT   = 2;
    localparam int ATTN_BIT  = 1;
    localparam int VEC_BIT   = 0;

    typedef enum logic {
        HREQ_IDLE = 1'b0,
        HREQ_PEND = 1'b1
    } hreq_state_t;
endpackage

// File: rtl/asr_decode.sv
module asr_decode
    import asr_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_wr,
    input  logic [OFS_W-1:0] acc_offset,
    input  logic             acc_wbit,
    input  logic             dummy_pend,
    output logic [FLAG_N-1:0] clr_hit,
    output logic             hreq_req,
    output logic             hreq_neg
);
    localparam logic [OFS_W-1:0] HREQ_OFS = OFS_W'(REG_W - 1);

    logic top_hit;

    genvar gi;
    generate
        for (gi = 0; gi < FLAG_N; gi++) begin : g_hit
            if (gi == LOCK_BIT) begin : g_lock
                assign clr_hit[gi] = acc_valid && (acc_offset == OFS_W'(gi)) && !dummy_pend;
            end else begin : g_plain
                assign clr_hit[gi] = acc_valid && (acc_offset == OFS_W'(gi));
            end
        end
    endgenerate

    always_comb begin
        top_hit  = acc_valid && (acc_offset == HREQ_OFS);
        hreq_req = top_hit && acc_wr && !acc_wbit;
        hreq_neg = top_hit && (!acc_wr || acc_wbit);
    end
endmodule

// File: rtl/asr_flag_bit.sv
module asr_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic set_val_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= set_val_i;
        else if (clr_i)
            q_o <= 1'b0;
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (q_o == $past(set_val_i)));
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/asr_hreq_fsm.sv
module asr_hreq_fsm
    import asr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic neg_i,
    input  logic ack_i,
    output logic host_irq_n_o
);
    hreq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= HREQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HREQ_IDLE: if (req_i)           state_d = HREQ_PEND;
            HREQ_PEND: if (ack_i || neg_i)  state_d = HREQ_IDLE;
            default:                        state_d = HREQ_IDLE;
        endcase
    end

    always_comb begin
        host_irq_n_o = (state_q != HREQ_PEND);
    end

    p_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HREQ_IDLE && req_i) |=> !host_irq_n_o);
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HREQ_IDLE && !req_i) |=> host_irq_n_o);
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HREQ_PEND && (ack_i || neg_i)) |=> host_irq_n_o);
endmodule

// File: rtl/attn_status_reg.sv
module attn_status_reg
    import asr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_wr,
    input  logic [OFS_W-1:0] acc_offset,
    input  logic             acc_wbit,
    input  logic             ev_vector_acc,
    input  logic             ev_vector_iack,
    input  logic             ev_host_attn,
    input  logic             ev_serial_irq,
    input  logic             ev_dma_fault,
    input  logic             ev_dbg_fault,
    input  logic             ev_abort,
    input  logic             ev_abort_dma,
    input  logic             ev_mem_delay,
    input  logic             dummy_pend,
    input  logic             host_ack,
    output logic [REG_W-1:0] rd_data,
    output logic             host_irq_n,
    output logic [IRQ_N-1:0] local_irq
);
    logic [FLAG_N-1:0] clr_hit;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] set_val;
    logic [FLAG_N-1:0] flags;
    logic              hreq_req;
    logic              hreq_neg;

    asr_decode u_decode (
        .acc_valid  (acc_valid),
        .acc_wr     (acc_wr),
        .acc_offset (acc_offset),
        .acc_wbit   (acc_wbit),
        .dummy_pend (dummy_pend),
        .clr_hit    (clr_hit),
        .hreq_req   (hreq_req),
        .hreq_neg   (hreq_neg)
    );

    always_comb begin
        set_vec            = '0;
        set_val            = '1;
        set_vec[VEC_BIT]   = ev_vector_acc && !ev_vector_iack;
        set_vec[ATTN_BIT]  = ev_host_attn;
        set_vec[SER_BIT]   = ev_serial_irq;
        set_vec[FAULT_BIT] = ev_dma_fault || ev_dbg_fault;
        set_vec[ABORT_BIT] = ev_abort;
        set_vec[KIND_BIT]  = ev_abort;
        set_val[KIND_BIT]  = ev_abort_dma;
        set_vec[LOCK_BIT]  = ev_mem_delay;
    end

    genvar gi;
    generate
        for (gi = 0; gi < FLAG_N; gi++) begin : g_flag
            asr_flag_bit u_bit (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_i     (set_vec[gi]),
                .set_val_i (set_val[gi]),
                .clr_i     (clr_hit[gi]),
                .q_o       (flags[gi])
            );
        end
    endgenerate

    asr_hreq_fsm u_hreq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (hreq_req),
        .neg_i        (hreq_neg),
        .ack_i        (host_ack),
        .host_irq_n_o (host_irq_n)
    );

    always_comb begin
        rd_data   = {host_irq_n, flags};
        local_irq = flags[IRQ_N-1:0];
    end

    p_iack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vector_acc && ev_vector_iack && !(acc_valid && acc_offset == OFS_W'(VEC_BIT)))
        |=> (rd_data[VEC_BIT] == $past(rd_data[VEC_BIT])));
    p_abort_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> (rd_data[ABORT_BIT] && rd_data[KIND_BIT] == $past(ev_abort_dma)));
    p_dummy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dummy_pend && !ev_mem_delay) |=> (rd_data[LOCK_BIT] == $past(rd_data[LOCK_BIT])));
    p_serial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_serial_irq |=> rd_data[SER_BIT]);
endmodule

// File: tb/tb_attn_status_reg.sv
`timescale 1ns/1ps
module tb_attn_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid, acc_wr, acc_wbit;
    logic [2:0] acc_offset;
    logic       ev_vector_acc, ev_vector_iack, ev_host_attn, ev_serial_irq;
    logic       ev_dma_fault, ev_dbg_fault, ev_abort, ev_abort_dma, ev_mem_delay;
    logic       dummy_pend, host_ack;
    logic [7:0] rd_data;
    logic       host_irq_n;
    logic [3:0] local_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;
    logic [7:0] exp_reg;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    attn_status_reg dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
        .acc_offset(acc_offset), .acc_wbit(acc_wbit),
        .ev_vector_acc(ev_vector_acc), .ev_vector_iack(ev_vector_iack),
        .ev_host_attn(ev_host_attn), .ev_serial_irq(ev_serial_irq),
        .ev_dma_fault(ev_dma_fault), .ev_dbg_fault(ev_dbg_fault),
        .ev_abort(ev_abort), .ev_abort_dma(ev_abort_dma),
        .ev_mem_delay(ev_mem_delay), .dummy_pend(dummy_pend),
        .host_ack(host_ack), .rd_data(rd_data), .host_irq_n(host_irq_n),
        .local_irq(local_irq)
    );

    function automatic logic [7:0] model(input logic [7:0] cur);
        logic [7:0] nx;
        logic [6:0] s, v, c;
        s = '0; v = '1; c = '0;
        s[0] = ev_vector_acc && !ev_vector_iack;
        s[1] = ev_host_attn;
        s[2] = ev_serial_irq;
        s[3] = ev_dma_fault || ev_dbg_fault;
        s[4] = ev_abort;
        s[5] = ev_abort; v[5] = ev_abort_dma;
        s[6] = ev_mem_delay;
        for (int i = 0; i < 7; i++) c[i] = acc_valid && (acc_offset == 3'(i));
        c[6] = c[6] && !dummy_pend;
        for (int i = 0; i < 7; i++) nx[i] = s[i] ? v[i] : (c[i] ? 1'b0 : cur[i]);
        if (cur[7])
            nx[7] = !(acc_valid && acc_offset == 3'd7 && acc_wr && !acc_wbit);
        else
            nx[7] = host_ack || (acc_valid && acc_offset == 3'd7 && (!acc_wr || acc_wbit));
        return nx;
    endfunction

    task automatic idle_inputs();
        acc_valid = 0; acc_wr = 0; acc_offset = 0; acc_wbit = 0;
        ev_vector_acc = 0; ev_vector_iack = 0; ev_host_attn = 0; ev_serial_irq = 0;
        ev_dma_fault = 0; ev_dbg_fault = 0; ev_abort = 0; ev_abort_dma = 0;
        ev_mem_delay = 0; dummy_pend = 0; host_ack = 0;
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    task automatic check_all(input string tag);
        check8({tag, " rd_data"}, rd_data, exp_reg);
        check8("R10 host_irq_n", {7'd0, host_irq_n}, {7'd0, exp_reg[7]});
        check8("R10 local_irq", {4'd0, local_irq}, {4'd0, exp_reg[3:0]});
    endtask

    // inputs already driven after a falling edge; one rising edge passes
    task automatic step(input string tag);
        logic [7:0] nx;
        nx = model(exp_reg);
        @(negedge clk);
        exp_reg = nx;
        check_all(tag);
        idle_inputs();
    endtask

    task automatic access(input logic [2:0] ofs, input logic wr, input logic wb);
        acc_valid = 1; acc_offset = ofs; acc_wr = wr; acc_wbit = wb;
    endtask

    initial begin
        idle_inputs();
        exp_reg = 8'h80;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1;
        @(negedge clk);
        check_all("R1 after release");

        ev_serial_irq = 1; step("R3 serial");
        ev_host_attn = 1; step("R3 attn");
        ev_dbg_fault = 1; step("R3 debugger fault");
        ev_mem_delay = 1; step("R3 mem delay");
        access(3'd2, 0, 0); step("R2 read clears bit2");
        access(3'd3, 1, 1); step("R2 write clears bit3");
        access(3'd1, 0, 0); ev_host_attn = 1; step("R4 set beats clear");
        ev_vector_acc = 1; ev_vector_iack = 1; step("R5 iack no set");
        ev_vector_acc = 1; step("R5 vector sets");
        ev_abort = 1; ev_abort_dma = 1; step("R6 abort during DMA");
        ev_abort = 1; ev_abort_dma = 0; step("R6 abort during PIO");
        access(3'd6, 0, 0); dummy_pend = 1; step("R7 dummy blocks clear");
        access(3'd6, 0, 0); step("R7 clear without dummy");
        access(3'd7, 1, 1); step("R8 write 1 stays idle");
        access(3'd7, 1, 0); step("R8 request");
        access(3'd5, 1, 0); step("R8 other offset keeps request");
        access(3'd7, 0, 0); step("R9 read releases");
        access(3'd7, 1, 0); step("R8 request again");
        access(3'd7, 1, 0); host_ack = 1; step("R9 ack beats request");
        access(3'd7, 1, 0); step("R8 request third");
        host_ack = 1; step("R9 host ack");

        void'($urandom(32'd2024));
        for (int k = 0; k < 3000; k++) begin
            acc_valid      = ($urandom % 3) == 0;
            acc_wr         = $urandom % 2;
            acc_offset     = 3'($urandom % 8);
            acc_wbit       = $urandom % 2;
            ev_vector_acc  = ($urandom % 8) == 0;
            ev_vector_iack = $urandom % 2;
            ev_host_attn   = ($urandom % 8) == 0;
            ev_serial_irq  = ($urandom % 8) == 0;
            ev_dma_fault   = ($urandom % 16) == 0;
            ev_dbg_fault   = ($urandom % 16) == 0;
            ev_abort       = ($urandom % 12) == 0;
            ev_abort_dma   = $urandom % 2;
            ev_mem_delay   = ($urandom % 10) == 0;
            dummy_pend     = ($urandom % 3) == 0;
            host_ack       = ($urandom % 6) == 0;
            step("R2,R3,R4,R7,R9 random");
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule